// File: doc/BRIEF.md
# DRAM Refresh and Start-up Scheduler

This block keeps an asynchronous page-mode DRAM array alive. It brings the array up after reset, then keeps the stored data valid during operation. It holds off all activity for a power-up pause. It then issues a burst of wake-up refresh cycles without asking the access arbiter for permission. After that it spaces refreshes evenly, so that every row is refreshed once within the retention period. Each refresh uses the CAS-before-RAS order, so the DRAM's internal row counter supplies the row address and no address bus is needed.

In normal operation a refresh is due each time the interval counter expires. The block raises a request to the access arbiter and starts the refresh strobes only when a grant comes back. Refreshes that are deferred are counted, and they run back-to-back once the grant is held. If the backlog reaches its limit and one more interval expires, the retention window is lost. The block then withdraws its init-done flag and repeats the full wake-up burst. That burst starts on one grant and then runs to its end. All strobe widths are ceilings of nanosecond parameters divided by the clock-period parameter.

Top module: `dram_rfsh_sched`

## Requirements
- R1: While reset is asserted, ras_n_o and cas_n_o are high, busy_o is high, and req_o and init_done_o are low.
- R2: For N_PAUSE = ceil(PAUSE_NS/CLK_NS) cycles after reset release, both strobes stay high and busy_o stays high. The first CAS fall comes in cycle N_PAUSE+1.
- R3: After the pause, WAKE_CYCLES refreshes run back-to-back with no grant, one every N_CSR+N_RAS+N_PRE cycles. init_done_o rises one cycle after the precharge of the last of them ends.
- R4: Each refresh drives cas_n_o low N_CSR = ceil(T_CSR_NS/CLK_NS) cycles before ras_n_o falls. RAS never falls while CAS is high.
- R5: ras_n_o stays low for exactly N_RAS cycles. N_RAS is the larger of ceil(T_RAS_NS/CLK_NS) and ceil(T_CHR_NS/CLK_NS). cas_n_o stays low throughout and rises in the same cycle as ras_n_o.
- R6: Between refreshes both strobes stay high for N_PRE cycles. N_PRE covers the RAS precharge time, the RAS-high-to-CAS-low time and the full cycle time T_RC_NS. RAS stays high for N_PRE+N_CSR cycles.
- R7: Once init_done_o is high, a refresh becomes pending every N_INT = floor(RETENTION_NS/ROWS/CLK_NS) cycles. req_o is high while a refresh is pending and the sequencer can start.
- R8: After init, no refresh starts unless grant_i is sampled high together with req_o. CAS falls on the following clock edge.
- R9: Deferred refreshes accumulate up to MAX_PEND. With grant_i held, they run back-to-back, and req_o drops once the backlog is empty.
- R10: When an interval expires with MAX_PEND already pending and none starting, init_done_o drops and the backlog clears. req_o rises to ask for the repeat of the wake-up burst. On the first grant all WAKE_CYCLES refreshes run back-to-back, and then init_done_o rises again.
- R11: busy_o is high during the pause, during a wake-up burst and whenever a strobe is low or a precharge is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grant_i | input | 1 | Arbiter grant for a requested refresh |
| req_o | output | 1 | Refresh request to the arbiter |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| busy_o | output | 1 | Scheduler owns the DRAM |
| init_done_o | output | 1 | Power-up or recovery wake-up burst finished |

## Verification
A strobe sequencer stuck in a wrong phase or count shows up at the next strobe edge. That edge moves off its scheduled cycle, or RAS falls with CAS still high, so the error is visible within one refresh period of 22 cycles at the bench settings. A wrong backlog count shows up later. It appears either as the wrong number of back-to-back refreshes once the grant arrives, or as a recovery burst that starts one interval too early or too late. A wake-up counter error moves the rise of init_done_o by whole refresh periods.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CSR, PH_RAS, PH_PRE} phase_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/rfsh_strobe_seq.sv
module rfsh_strobe_seq
  import rfsh_pkg::*;
#(
  parameter int N_CSR = 1,
  parameter int N_RAS = 6,
  parameter int N_PRE = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic ready_o,
  output logic active_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int NMAX = imax(imax(N_CSR, N_RAS), N_PRE);
  localparam int CW   = $clog2(NMAX + 1);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ras_n_q, cas_n_q;

  assign done_o   = (phase_q == PH_PRE) && (cnt_q == '0);
  assign ready_o  = (phase_q == PH_IDLE) || done_o;
  assign active_o = (phase_q != PH_IDLE);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_CSR;
        cnt_d   = CW'(N_CSR - 1);
      end
      PH_CSR: if (cnt_q == '0) begin
        phase_d = PH_RAS;
        cnt_d   = CW'(N_RAS - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_RAS: if (cnt_q == '0) begin
        phase_d = PH_PRE;
        cnt_d   = CW'(N_PRE - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_PRE: if (cnt_q == '0) begin
        // chain straight into the next refresh when asked
        phase_d = start_i ? PH_CSR : PH_IDLE;
        cnt_d   = start_i ? CW'(N_CSR - 1) : '0;
      end else cnt_d = cnt_q - 1'b1;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ras_n_q <= (phase_d != PH_RAS);
      cas_n_q <= !((phase_d == PH_CSR) || (phase_d == PH_RAS));
    end
  end

  assign ras_n_o = ras_n_q;
  assign cas_n_o = cas_n_q;
endmodule

// File: rtl/rfsh_interval.sv
module rfsh_interval #(
  parameter int N_INT    = 1562,
  parameter int MAX_PEND = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic take_i,
  output logic has_pend_o,
  output logic overrun_o
);
  localparam int TW = $clog2(N_INT + 1);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [TW-1:0] tmr_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick       = en_i && (tmr_q == TW'(N_INT - 1));
  assign overrun_o  = tick && !take_i && (pend_q == PW'(MAX_PEND));
  assign has_pend_o = (pend_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q  <= '0;
      pend_q <= '0;
    end else begin
      if (!en_i || tick) tmr_q <= '0;
      else               tmr_q <= tmr_q + 1'b1;

      if (overrun_o)                                         pend_q <= '0;
      else if (tick && !take_i)                              pend_q <= pend_q + 1'b1;
      else if (!tick && take_i && pend_q != '0)              pend_q <= pend_q - 1'b1;
    end
  end
endmodule

// File: rtl/dram_rfsh_sched.sv
module dram_rfsh_sched
  import rfsh_pkg::*;
#(
  parameter int CLK_NS       = 10,
  parameter int PAUSE_NS     = 100_000,
  parameter int RETENTION_NS = 16_000_000,
  parameter int ROWS         = 1024,
  parameter int WAKE_CYCLES  = 8,
  parameter int MAX_PEND     = 8,
  parameter int T_CSR_NS     = 10,
  parameter int T_CHR_NS     = 10,
  parameter int T_RAS_NS     = 60,
  parameter int T_RP_NS      = 40,
  parameter int T_RPC_NS     = 5,
  parameter int T_RC_NS      = 110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic grant_i,
  output logic req_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic busy_o,
  output logic init_done_o
);
  localparam int N_PAUSE = imax(ceil_div(PAUSE_NS, CLK_NS), 1);
  localparam int N_CSR   = imax(ceil_div(T_CSR_NS, CLK_NS), 1);
  localparam int N_RAS   = imax(ceil_div(T_RAS_NS, CLK_NS), ceil_div(T_CHR_NS, CLK_NS));
  localparam int N_RP    = imax(imax(ceil_div(T_RP_NS, CLK_NS), ceil_div(T_RPC_NS, CLK_NS)), 1);
  localparam int N_PRE   = imax(N_RP, ceil_div(T_RC_NS, CLK_NS) - N_RAS - N_CSR);
  localparam int N_INT   = (RETENTION_NS / ROWS) / CLK_NS;
  localparam int PCW     = $clog2(N_PAUSE + 1);
  localparam int WCW     = $clog2(WAKE_CYCLES + 1);

  logic           boot_q, wake_gnt_q, init_done_q;
  logic [PCW-1:0] pause_q;
  logic [WCW-1:0] wake_left_q;
  logic           seq_ready, seq_active, seq_done;
  logic           has_pend, overrun;
  logic           wake_go, norm_go;

  assign wake_go = !boot_q && (wake_left_q != '0) && seq_ready && (!wake_gnt_q || grant_i);
  assign norm_go = init_done_q && has_pend && seq_ready && grant_i;

  rfsh_strobe_seq #(
    .N_CSR(N_CSR), .N_RAS(N_RAS), .N_PRE(N_PRE)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (wake_go || norm_go),
    .ready_o (seq_ready),
    .active_o(seq_active),
    .done_o  (seq_done),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o)
  );

  rfsh_interval #(
    .N_INT(N_INT), .MAX_PEND(MAX_PEND)
  ) u_int (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (init_done_q),
    .take_i    (norm_go),
    .has_pend_o(has_pend),
    .overrun_o (overrun)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q      <= 1'b1;
      pause_q     <= '0;
      wake_left_q <= WCW'(WAKE_CYCLES);
      wake_gnt_q  <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      if (boot_q) begin
        pause_q <= pause_q + 1'b1;
        if (pause_q == PCW'(N_PAUSE - 1)) boot_q <= 1'b0;
      end
      if (overrun) begin
        // retention window lost: redo the wake-up burst after one grant
        init_done_q <= 1'b0;
        wake_left_q <= WCW'(WAKE_CYCLES);
        wake_gnt_q  <= 1'b1;
      end else begin
        if (wake_go) begin
          wake_left_q <= wake_left_q - 1'b1;
          wake_gnt_q  <= 1'b0;
        end
        if (seq_done && wake_left_q == '0) init_done_q <= 1'b1;
      end
    end
  end

  assign req_o       = seq_ready && !boot_q &&
                       ((init_done_q && has_pend) || (wake_left_q != '0 && wake_gnt_q));
  assign busy_o      = boot_q || seq_active || (wake_left_q != '0 && !wake_gnt_q);
  assign init_done_o = init_done_q;
endmodule

// File: rtl/dram_rfsh_sched_chk.sv
module dram_rfsh_sched_chk #(
  parameter int N_CSR = 1,
  parameter int N_RAS = 6,
  parameter int N_PRE = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic grant_i,
  input logic req_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic busy_o,
  input logic init_done_o
);
  localparam int LW = $clog2(N_RAS + 2);
  localparam int HW = $clog2(N_PRE + N_CSR + 2);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= ras_n_o ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt <= !ras_n_o ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
    end
  end

  // R4
  cas_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R5
  cas_with_ras_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cas_n_o) |-> $rose(ras_n_o));

  // R5
  ras_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) |-> (lo_cnt == LW'(N_RAS)));

  // R6
  precharge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> (hi_cnt >= HW'(N_PRE + N_CSR)));

  // R8
  grant_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n_o) && $past(init_done_o)) |-> ($past(grant_i) && $past(req_o)));

  // R11
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ras_n_o || !cas_n_o) |-> busy_o);

  // R7
  req_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (ras_n_o && cas_n_o));

  // R3
  init_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(init_done_o) |-> (ras_n_o && cas_n_o));
endmodule

bind dram_rfsh_sched dram_rfsh_sched_chk #(
  .N_CSR(N_CSR), .N_RAS(N_RAS), .N_PRE(N_PRE)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .grant_i    (grant_i),
  .req_o      (req_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .busy_o     (busy_o),
  .init_done_o(init_done_o)
);

// File: tb/dram_rfsh_sched_tb_top.sv
module dram_rfsh_sched_tb_top;
  // bench settings: 5 ns clock -> csr 2, ras 12, pre 8 cycles; pause 100; interval 200
  localparam int P_CSR   = 2;
  localparam int P_RAS   = 12;
  localparam int P_PRE   = 8;
  localparam int P_REF   = P_CSR + P_RAS + P_PRE;
  localparam int P_PAUSE = 100;
  localparam int P_INT   = 200;

  typedef enum int {EV_CAS_FALL, EV_RAS_FALL, EV_RAS_RISE} ev_e;
  typedef struct {ev_e kind; int cyc; string req;} ev_t;

  logic clk, rst_ni, grant;
  logic req, ras_n, cas_n, busy, init_done;
  int   cyc, errors, checks;
  ev_t  exp_q[$];

  dram_rfsh_sched #(
    .CLK_NS(5), .PAUSE_NS(500), .RETENTION_NS(1_024_000), .ROWS(1024),
    .WAKE_CYCLES(8), .MAX_PEND(4)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .grant_i(grant), .req_o(req),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .busy_o(busy), .init_done_o(init_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) if (rst_ni) cyc <= cyc + 1;

  task automatic chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", r, cyc, act, exp);
    end
  endtask

  task automatic push_burst(int first, int n, string r);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{EV_CAS_FALL, first + i*P_REF, r});
      exp_q.push_back('{EV_RAS_FALL, first + i*P_REF + P_CSR, r});
      exp_q.push_back('{EV_RAS_RISE, first + i*P_REF + P_CSR + P_RAS, r});
    end
  endtask

  task automatic wait_cyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic pop_cmp(ev_e k);
    ev_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R8 unexpected strobe edge kind=%0d cyc=%0d actual=%0d expected=none",
               k, cyc, cyc);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != k || e.cyc != cyc) begin
        errors++;
        $display("FAIL %s edge kind actual=%0d expected=%0d cyc actual=%0d expected=%0d",
                 e.req, k, e.kind, cyc, e.cyc);
      end
    end
  endtask

  // monitor: strobe edges against the scoreboard
  logic ras_p, cas_p;
  always @(negedge clk) begin
    if (!rst_ni) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
    end else begin
      if (cas_p && !cas_n) pop_cmp(EV_CAS_FALL);
      if (ras_p && !ras_n) begin
        pop_cmp(EV_RAS_FALL);
        chk("R4 cas low at ras fall", cas_n, 0);
      end
      if (!ras_p && ras_n) begin
        pop_cmp(EV_RAS_RISE);
        chk("R5 cas rises with ras", cas_n, 1);
      end else if (!cas_p && cas_n) begin
        chk("R5 cas rose without ras", 1, 0);
      end
      ras_p <= ras_n;
      cas_p <= cas_n;
    end
  end

  initial begin
    errors = 0; checks = 0; cyc = 0;
    rst_ni = 1'b0; grant = 1'b0;
    fork
      begin : main_seq
        repeat (3) @(negedge clk);
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 busy", busy, 1);
        chk("R1 req", req, 0);
        chk("R1 init_done", init_done, 0);
        push_burst(P_PAUSE + 1, 8, "R3");
        rst_ni = 1'b1;

        wait_cyc(50);
        chk("R2 busy in pause", busy, 1);
        chk("R2 ras_n in pause", ras_n, 1);
        wait_cyc(P_PAUSE);
        chk("R2 cas_n at pause end", cas_n, 1);
        wait_cyc(P_PAUSE + 1);
        chk("R2 first cas fall", cas_n, 0);
        chk("R11 busy during burst", busy, 1);

        wait_cyc(P_PAUSE + 8*P_REF);
        chk("R3 init_done early", init_done, 0);
        wait_cyc(P_PAUSE + 1 + 8*P_REF);            // 277
        chk("R3 init_done", init_done, 1);
        wait_cyc(300);
        chk("R11 busy idle", busy, 0);

        wait_cyc(276 + P_INT);
        chk("R7 req before interval", req, 0);
        wait_cyc(277 + P_INT);                      // 477
        chk("R7 req at interval", req, 1);

        wait_cyc(880);                              // three pending, no grant
        chk("R8 req held", req, 1);
        chk("R8 no strobe without grant", ras_n & cas_n, 1);
        wait_cyc(900);
        push_burst(901, 3, "R9");
        grant = 1'b1;
        wait_cyc(960);
        chk("R9 req after backlog", req, 0);
        wait_cyc(1000);
        grant = 1'b0;

        wait_cyc(277 + 4*P_INT);                    // 1077
        chk("R7 req next tick", req, 1);
        wait_cyc(1876);
        chk("R10 init_done before overrun", init_done, 1);
        wait_cyc(1877);
        chk("R10 init_done drops", init_done, 0);
        chk("R10 req for recovery", req, 1);
        wait_cyc(1900);
        push_burst(1901, 8, "R10");
        grant = 1'b1;
        wait_cyc(1901);
        grant = 1'b0;
        wait_cyc(1900 + 8*P_REF);
        chk("R10 init_done early", init_done, 0);
        wait_cyc(1901 + 8*P_REF);                   // 2077
        chk("R10 init_done again", init_done, 1);
        wait_cyc(2100);
        chk("R10 backlog cleared", req, 0);
        wait_cyc(2076 + P_INT);
        chk("R7 req before restart tick", req, 0);
        wait_cyc(2077 + P_INT);
        chk("R7 req restart tick", req, 1);
        wait_cyc(2300);
        chk("R9 scoreboard drained", exp_q.size(), 0);
      end
      begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule